// File: doc/BRIEF.md
# Counter Increment Request Arbiter

This block keeps track of which of eight hardware counters is waiting to count up or down, and picks one of them for the counter service sequence. Each cell holds a pending-up flag and a pending-down flag. The flags are set by request pulses from timers and other sources. A sync strobe copies all sixteen flags into a pair of latch registers in one cycle. A fixed-priority encoder then works only from that latched copy, so the cell being serviced cannot change while its service is under way.

The encoder reports the winning cell, a service code (increment, decrement or no-op) and, when asked, the memory address of that counter. A write-back strobe at the end of service retires the latched request. On that strobe the block also looks at the overflow code from the external adder. A positive overflow of the first timer is carried into a request on the second timer. Positive overflows of the third and fourth timers raise interrupt pulses. A separate overflow-count strobe turns any positive or negative overflow into a request on the overflow counter, which is cell 0.

Top module: `ctr_req_arbiter`

## Requirements
- R1: A high bit on `req_up[i]` or `req_dn[i]` sets that cell's pending-up or pending-down flag at the next clock edge. The flag stays set until it is cleared.
- R2: The latched copies change only on a clock edge where `sync_stb` is high. On that edge all eight up flags and all eight down flags are copied together.
- R3: `sel_idx` is the lowest-numbered cell whose latched up bit or latched down bit is set. When no latched bit is set, `sel_idx` is 7.
- R4: `svc_code` is 2'b01 (increment) when only the selected cell's latched up bit is set. It is 2'b10 (decrement) when only its latched down bit is set. Otherwise it is 2'b00, and it is never 2'b11.
- R5: While `rd_stb` is high, `addr_out` is 28 (octal 034) plus `sel_idx`. While `rd_stb` is low, `addr_out` is 0.
- R6: A clock edge with `wb_stb` high clears the selected cell's pending-up flag if its latched up bit is set. It clears the pending-down flag if its latched down bit is set.
- R7: A clock edge with `wb_stb` high, `ovf_code` = 2'b01 (positive) and `sel_idx` = 2 sets the pending-up flag of cell 1.
- R8: A clock edge with `wb_stb` high and `ovf_code` = 2'b01 makes `irq_t3` high for the next cycle when `sel_idx` = 3, and makes `irq_t4` high for the next cycle when `sel_idx` = 4. With `ovf_code` = 2'b10 (negative) or 2'b00 (none), the write-back raises no interrupt and chains no request.
- R9: A clock edge with `ovc_stb` high sets cell 0's pending-up flag when `ovf_code` = 2'b01 and its pending-down flag when `ovf_code` = 2'b10.
- R10: While `rst_n` is low, all pending flags, both latch registers and both interrupt outputs are cleared. `sel_idx` is then 7 and `svc_code` is 2'b00.
- R11: If a flag is set by any source on the same edge on which write-back clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous general reset |
| req_up | input | 8 | Per-cell increment request pulses |
| req_dn | input | 8 | Per-cell decrement request pulses |
| sync_stb | input | 1 | Copy pending flags into latch registers |
| rd_stb | input | 1 | Drive the selected counter address |
| wb_stb | input | 1 | Retire selected request, act on overflow |
| ovc_stb | input | 1 | Route overflow into the overflow counter |
| ovf_code | input | 2 | Overflow code: 00 none, 01 positive, 10 negative |
| sel_idx | output | 3 | Selected cell index |
| svc_code | output | 2 | Service code: 01 inc, 10 dec, 00 no-op |
| addr_out | output | 12 | Counter memory address, 0 when not read |
| irq_t3 | output | 1 | Interrupt pulse on third-timer overflow |
| irq_t4 | output | 1 | Interrupt pulse on fourth-timer overflow |

## Verification
The bench builds the block with its default parameters: eight cells, a 12-bit address with base 28, and overflow chaining enabled. These values bring every fixed role within reach: the overflow counter, the chain from cell 2 into cell 1, and the two interrupt sources. They also put the idle index 7 on the boundary of a 3-bit select. Directed sequences drive the chain, both interrupt pulses, a negative write-back, both overflow-count codes, and a request landing on the edge that clears it. Sparse pseudo-random traffic then mixes the strobes, so that write-backs, syncs and requests collide in many orders.

// File: rtl/ctr_arb_pkg.sv
package ctr_arb_pkg;
   typedef enum logic [1:0] {
      SVC_NOP = 2'b00,
      SVC_INC = 2'b01,
      SVC_DEC = 2'b10
   } svc_e;

   typedef enum logic [1:0] {
      OVF_NONE = 2'b00,
      OVF_POS  = 2'b01,
      OVF_NEG  = 2'b10
   } ovf_e;
endpackage

// File: rtl/ctr_pend_bank.sv
// Pending request flags and their latched copies, one slice per cell.
module ctr_pend_bank #(
   parameter int NCELL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCELL-1:0] set_up,
   input  logic [NCELL-1:0] set_dn,
   input  logic [NCELL-1:0] clr_up,
   input  logic [NCELL-1:0] clr_dn,
   input  logic             sync_stb,
   output logic [NCELL-1:0] lat_up,
   output logic [NCELL-1:0] lat_dn
);
   logic [NCELL-1:0] pend_up;
   logic [NCELL-1:0] pend_dn;

   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      // a set on the same edge as a clear leaves the flag set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_up[c] <= 1'b0;
            pend_dn[c] <= 1'b0;
         end else begin
            pend_up[c] <= set_up[c] | (pend_up[c] & ~clr_up[c]);
            pend_dn[c] <= set_dn[c] | (pend_dn[c] & ~clr_dn[c]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lat_up[c] <= 1'b0;
            lat_dn[c] <= 1'b0;
         end else if (sync_stb) begin
            lat_up[c] <= pend_up[c];
            lat_dn[c] <= pend_dn[c];
         end
      end
   end
endmodule

// File: rtl/ctr_prio_enc.sv
// Fixed-priority pick over the latched requests, lowest index wins.
module ctr_prio_enc
   import ctr_arb_pkg::*;
#(
   parameter int NCELL = 8,
   parameter int IDX_W = $clog2(NCELL)
) (
   input  logic [NCELL-1:0] lat_up,
   input  logic [NCELL-1:0] lat_dn,
   output logic [IDX_W-1:0] sel_idx,
   output logic [NCELL-1:0] sel_hot,
   output logic [1:0]       svc_code
);
   logic [NCELL-1:0] any_req;
   logic             hit;
   logic             sel_u;
   logic             sel_d;

   assign any_req = lat_up | lat_dn;

   always_comb begin
      sel_idx = IDX_W'(NCELL - 1);
      hit     = 1'b0;
      for (int i = 0; i < NCELL; i++) begin
         if (!hit && any_req[i]) begin
            sel_idx = IDX_W'(i);
            hit     = 1'b1;
         end
      end
   end

   assign sel_hot = NCELL'(1) << sel_idx;
   assign sel_u   = |(lat_up & sel_hot);
   assign sel_d   = |(lat_dn & sel_hot);

   always_comb begin
      svc_e code;
      unique case ({sel_u, sel_d})
         2'b10:   code = SVC_INC;
         2'b01:   code = SVC_DEC;
         default: code = SVC_NOP;
      endcase
      svc_code = code;
   end
endmodule

// File: rtl/ctr_ovf_route.sv
// Turns overflow codes into chained requests and interrupt pulses.
module ctr_ovf_route
   import ctr_arb_pkg::*;
#(
   parameter int NCELL     = 8,
   parameter int IDX_W     = $clog2(NCELL),
   parameter int OVF_CELL  = 0,
   parameter int CHAIN_SRC = 2,
   parameter int CHAIN_DST = 1,
   parameter int IRQA_SRC  = 3,
   parameter int IRQB_SRC  = 4,
   parameter bit CHAIN_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wb_stb,
   input  logic             ovc_stb,
   input  logic [1:0]       ovf_code,
   input  logic [IDX_W-1:0] sel_idx,
   output logic [NCELL-1:0] int_up,
   output logic [NCELL-1:0] int_dn,
   output logic             irq_a,
   output logic             irq_b
);
   logic pos_ovf;
   logic neg_ovf;
   logic wb_pos;
   logic [NCELL-1:0] chain_up;
   logic [NCELL-1:0] ovc_up;
   logic [NCELL-1:0] ovc_dn;

   assign pos_ovf = (ovf_code == OVF_POS);
   assign neg_ovf = (ovf_code == OVF_NEG);
   assign wb_pos  = wb_stb & pos_ovf;

   assign ovc_up = (ovc_stb & pos_ovf) ? NCELL'(1) << OVF_CELL : '0;
   assign ovc_dn = (ovc_stb & neg_ovf) ? NCELL'(1) << OVF_CELL : '0;

   if (CHAIN_EN) begin : g_chain
      assign chain_up = (wb_pos && sel_idx == IDX_W'(CHAIN_SRC))
                        ? NCELL'(1) << CHAIN_DST : '0;
   end else begin : g_nochain
      assign chain_up = '0;
   end

   assign int_up = chain_up | ovc_up;
   assign int_dn = ovc_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= wb_pos && (sel_idx == IDX_W'(IRQA_SRC));
         irq_b <= wb_pos && (sel_idx == IDX_W'(IRQB_SRC));
      end
   end
endmodule

// File: rtl/ctr_req_arbiter.sv
// Top: request collection, priority pick, service code and overflow routing.
module ctr_req_arbiter #(
   parameter int          NCELL     = 8,
   parameter int          ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 28,
   parameter int          OVF_CELL  = 0,
   parameter int          CHAIN_SRC = 2,
   parameter int          CHAIN_DST = 1,
   parameter int          IRQA_SRC  = 3,
   parameter int          IRQB_SRC  = 4,
   parameter bit          CHAIN_EN  = 1'b1,
   localparam int         IDX_W     = $clog2(NCELL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCELL-1:0]  req_up,
   input  logic [NCELL-1:0]  req_dn,
   input  logic              sync_stb,
   input  logic              rd_stb,
   input  logic              wb_stb,
   input  logic              ovc_stb,
   input  logic [1:0]        ovf_code,
   output logic [IDX_W-1:0]  sel_idx,
   output logic [1:0]        svc_code,
   output logic [ADDR_W-1:0] addr_out,
   output logic              irq_t3,
   output logic              irq_t4
);
   if (NCELL < 5 || NCELL > 64) begin : g_bad_ncell
      $error("ctr_req_arbiter: NCELL must be 5..64");
   end
   if (BASE_ADDR + NCELL > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("ctr_req_arbiter: BASE_ADDR + NCELL exceeds ADDR_W");
   end
   if (OVF_CELL >= NCELL || CHAIN_SRC >= NCELL || CHAIN_DST >= NCELL ||
       IRQA_SRC >= NCELL || IRQB_SRC >= NCELL) begin : g_bad_role
      $error("ctr_req_arbiter: cell role index out of range");
   end

   logic [NCELL-1:0] lat_up;
   logic [NCELL-1:0] lat_dn;
   logic [NCELL-1:0] sel_hot;
   logic [NCELL-1:0] int_up;
   logic [NCELL-1:0] int_dn;
   logic [NCELL-1:0] clr_up;
   logic [NCELL-1:0] clr_dn;

   // retire only the latched direction(s) of the selected cell
   assign clr_up = wb_stb ? (lat_up & sel_hot) : '0;
   assign clr_dn = wb_stb ? (lat_dn & sel_hot) : '0;

   ctr_pend_bank #(.NCELL(NCELL)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_up   (req_up | int_up),
      .set_dn   (req_dn | int_dn),
      .clr_up   (clr_up),
      .clr_dn   (clr_dn),
      .sync_stb (sync_stb),
      .lat_up   (lat_up),
      .lat_dn   (lat_dn)
   );

   ctr_prio_enc #(.NCELL(NCELL), .IDX_W(IDX_W)) u_enc (
      .lat_up   (lat_up),
      .lat_dn   (lat_dn),
      .sel_idx  (sel_idx),
      .sel_hot  (sel_hot),
      .svc_code (svc_code)
   );

   ctr_ovf_route #(
      .NCELL(NCELL), .IDX_W(IDX_W), .OVF_CELL(OVF_CELL),
      .CHAIN_SRC(CHAIN_SRC), .CHAIN_DST(CHAIN_DST),
      .IRQA_SRC(IRQA_SRC), .IRQB_SRC(IRQB_SRC), .CHAIN_EN(CHAIN_EN)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .wb_stb   (wb_stb),
      .ovc_stb  (ovc_stb),
      .ovf_code (ovf_code),
      .sel_idx  (sel_idx),
      .int_up   (int_up),
      .int_dn   (int_dn),
      .irq_a    (irq_t3),
      .irq_b    (irq_t4)
   );

   assign addr_out = rd_stb ? ADDR_W'(BASE_ADDR) + ADDR_W'(sel_idx) : '0;
endmodule

// File: rtl/ctr_req_arbiter_chk.sv
module ctr_req_arbiter_chk #(
   parameter int          NCELL     = 8,
   parameter int          ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 28,
   parameter int          IRQA_SRC  = 3,
   parameter int          IRQB_SRC  = 4,
   localparam int         IDX_W     = $clog2(NCELL)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_stb,
   input logic              rd_stb,
   input logic              wb_stb,
   input logic [1:0]        ovf_code,
   input logic [IDX_W-1:0]  sel_idx,
   input logic [1:0]        svc_code,
   input logic [ADDR_W-1:0] addr_out,
   input logic              irq_t3,
   input logic              irq_t4
);
   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync_stb) |-> ($stable(sel_idx) && $stable(svc_code)));

   // R4
   svc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_code != 2'b11);

   // R5
   addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> addr_out == ADDR_W'(BASE_ADDR) + ADDR_W'(sel_idx));

   // R5
   addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> addr_out == '0);

   // R8
   irq_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_t3 |-> ($past(wb_stb) && $past(ovf_code) == 2'b01 &&
                  $past(sel_idx) == IDX_W'(IRQA_SRC)));

   // R8
   irq_b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_t4 |-> ($past(wb_stb) && $past(ovf_code) == 2'b01 &&
                  $past(sel_idx) == IDX_W'(IRQB_SRC)));

   // R8
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({irq_t3, irq_t4}) <= 1);
endmodule

bind ctr_req_arbiter ctr_req_arbiter_chk #(
   .NCELL(NCELL), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
   .IRQA_SRC(IRQA_SRC), .IRQB_SRC(IRQB_SRC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .rd_stb(rd_stb),
   .wb_stb(wb_stb), .ovf_code(ovf_code), .sel_idx(sel_idx),
   .svc_code(svc_code), .addr_out(addr_out),
   .irq_t3(irq_t3), .irq_t4(irq_t4)
);

// File: tb/ctr_req_arbiter_tb.sv
module ctr_req_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req_up = '0, req_dn = '0;
   logic        sync_stb = 0, rd_stb = 0, wb_stb = 0, ovc_stb = 0;
   logic [1:0]  ovf_code = '0;
   logic [2:0]  sel_idx;
   logic [1:0]  svc_code;
   logic [11:0] addr_out;
   logic        irq_t3, irq_t4;

   int n_chk = 0, n_fail = 0;

   // reference state
   bit m_pu[N], m_pd[N], m_lu[N], m_ld[N];
   bit m_ia, m_ib;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctr_req_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_dn(req_dn),
      .sync_stb(sync_stb), .rd_stb(rd_stb), .wb_stb(wb_stb),
      .ovc_stb(ovc_stb), .ovf_code(ovf_code), .sel_idx(sel_idx),
      .svc_code(svc_code), .addr_out(addr_out),
      .irq_t3(irq_t3), .irq_t4(irq_t4)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_sel();
      for (int i = 0; i < N; i++) if (m_lu[i] || m_ld[i]) return i;
      return 7;
   endfunction

   // one cycle: drive at negedge, compare, advance the model to the next edge
   task automatic step(bit rst, bit [7:0] up, bit [7:0] dn, bit sy, bit rd,
                       bit wb, bit ovc, bit [1:0] ov);
      int s, sv;
      bit npu[N], npd[N];
      @(negedge clk);
      rst_n = ~rst; req_up = up; req_dn = dn; sync_stb = sy; rd_stb = rd;
      wb_stb = wb; ovc_stb = ovc; ovf_code = ov;
      if (rst) begin
         foreach (m_pu[i]) begin m_pu[i] = 0; m_pd[i] = 0; m_lu[i] = 0; m_ld[i] = 0; end
         m_ia = 0; m_ib = 0;
      end
      #1;
      s  = exp_sel();
      sv = (m_lu[s] && !m_ld[s]) ? 1 : (m_ld[s] && !m_lu[s]) ? 2 : 0;
      chk("R3 sel_idx (R10 after reset)", int'(sel_idx), s);
      chk("R4 svc_code", int'(svc_code), sv);
      chk("R5 addr_out", int'(addr_out), rd ? 28 + s : 0);
      chk("R8 irq_t3", int'(irq_t3), int'(m_ia));
      chk("R8 irq_t4", int'(irq_t4), int'(m_ib));
      if (rst) return;
      npu = m_pu; npd = m_pd;
      if (wb && m_lu[s]) npu[s] = 0;              // R6
      if (wb && m_ld[s]) npd[s] = 0;
      for (int i = 0; i < N; i++) begin           // R1, R11
         if (up[i]) npu[i] = 1;
         if (dn[i]) npd[i] = 1;
      end
      if (wb && ov == 2'b01 && s == 2) npu[1] = 1; // R7
      if (ovc && ov == 2'b01) npu[0] = 1;          // R9
      if (ovc && ov == 2'b10) npd[0] = 1;
      m_ia = wb && ov == 2'b01 && s == 3;          // R8
      m_ib = wb && ov == 2'b01 && s == 4;
      if (sy) begin m_lu = m_pu; m_ld = m_pd; end  // R2
      m_pu = npu; m_pd = npd;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
   endtask

   initial begin : main
      // R10 reset state
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 0, 0, 0);
      idle(1);
      // R1/R2: request held pending, not visible until sync
      step(0, 8'h20, 8'h00, 0, 1, 0, 0, 0);
      idle(2);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      idle(1);
      // R7: cell 2 positive overflow chains into cell 1
      step(0, 8'h04, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 2'b01);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0);
      // R8: cells 3 and 4 positive, then negative on 3
      step(0, 8'h08, 8'h10, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 2'b01);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 2'b01);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 8'h08, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 2'b10);
      idle(2);
      // R9: overflow-count strobe both signs, R4 both-set no-op
      step(0, 0, 0, 0, 1, 0, 1, 2'b01);
      step(0, 0, 0, 0, 1, 0, 1, 2'b10);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      // R11: new request on the edge that clears it
      step(0, 8'h40, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 8'h40, 0, 0, 1, 1, 0, 0);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      idle(1);
      // mixed traffic
      for (int k = 0; k < 4000; k++) begin
         bit [7:0] u, d;
         int o;
         u = 8'($urandom & $urandom & $urandom);
         d = 8'($urandom & $urandom & $urandom);
         o = $urandom_range(0, 2);
         step(k == 2000, u, d, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0, 2'(o));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule